// File: doc/BRIEF.md
# Next Program Counter Generator

This purely combinational block produces the address of the following instruction for a processor that completes one instruction per clock. It takes the current program counter, the fetched instruction word, the value read from the first source register, and a two-bit target select from the control decoder. From these it forms four candidate addresses and returns the selected one:
- the sequential address;
- a word-scaled PC-relative branch target;
- a register-held target;
- an absolute target that stays inside the current 256 MB region.

The block also returns the sequential address on a separate output. Jump-and-link instructions write that value back to the register file.

Branch conditions are evaluated outside the block. The decoder folds the condition into the select, so a branch that is not taken arrives as the sequential code. The program counter register sits outside the block and loads the next-address output at each clock edge.

Top module: `nextpc_gen`

## Requirements
- R1: When `pc_sel_i` is 2'b00, `next_pc_o` equals `pc_i` + 4.
- R2: `link_o` equals `pc_i` + 4 for every value of `pc_sel_i`.
- R3: When `pc_sel_i` is 2'b01, `next_pc_o` equals `pc_i` + 4 plus the sign-extended `instr_i[15:0]` shifted left by 2. The offset field counts words.
- R4: A branch offset with bit 15 set moves the target backwards. For example, 16'hFFFF gives `pc_i` + 4 − 4.
- R5: When `pc_sel_i` is 2'b10, `next_pc_o` equals `rs_val_i` exactly, including its two low bits.
- R6: When `pc_sel_i` is 2'b11, `next_pc_o` is built from three parts, most significant first: `pc_i[31:28]`, then `instr_i[25:0]`, then 2'b00.
- R7: The upper four bits of the absolute target come from `pc_i`, not from `pc_i` + 4. This holds even when `pc_i` + 4 crosses into the next 256 MB region.
- R8: All additions wrap modulo 2^32. For example, `pc_i` = 32'hFFFFFFFC gives a sequential address of 0.
- R9: Inputs that the selected target does not use have no effect on `next_pc_o`. Under 2'b00, `instr_i` and `rs_val_i` are ignored. Under 2'b01 and 2'b11, `rs_val_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_i | input | 32 | Current program counter |
| instr_i | input | 32 | Fetched instruction word |
| rs_val_i | input | 32 | Value read from the first source register |
| pc_sel_i | input | 2 | Target select: 00 sequential, 01 branch, 10 register, 11 absolute jump |
| next_pc_o | output | 32 | Address of the following instruction |
| link_o | output | 32 | Return address for jump-and-link write-back |

## Verification
Both results depend on the current inputs alone and are due in the same cycle the stimulus is applied, with no register in the path. The driver applies a stimulus just after a rising edge and pushes the expected pair into a queue. The monitor pops and compares that pair at the following falling edge, which keeps every comparison half a period clear of input changes. The region-crossing jump and the wrap-around cases each use a program counter chosen so that a wrong upper-bit source or a lost carry changes the result.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;
  localparam int unsigned XLEN       = 32;
  localparam int unsigned BR_OFF_W   = 16;
  localparam int unsigned JMP_IDX_W  = 26;
  localparam int unsigned WORD_SHIFT = 2;
  localparam int unsigned STEP_BYTES = 4;

  typedef enum logic [1:0] {
    PCSEL_SEQ    = 2'b00,
    PCSEL_BRANCH = 2'b01,
    PCSEL_REG    = 2'b10,
    PCSEL_JUMP   = 2'b11
  } pcsel_e;
endpackage

// File: rtl/pc_seq_adder.sv
module pc_seq_adder #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned STEP_BYTES = 4
) (
  input  logic [XLEN-1:0] pc_i,
  output logic [XLEN-1:0] seq_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(STEP_BYTES);

  always_comb begin
    seq_o = pc_i + STEP;
  end
endmodule

// File: rtl/pc_branch_target.sv
module pc_branch_target #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned OFF_W      = 16,
  parameter int unsigned WORD_SHIFT = 2
) (
  input  logic [XLEN-1:0]  base_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [XLEN-1:0]  tgt_o
);
  localparam int unsigned EXT_W = XLEN - OFF_W - WORD_SHIFT;

  logic [XLEN-1:0] scaled_off;

  always_comb begin
    scaled_off = {{EXT_W{off_i[OFF_W-1]}}, off_i, {WORD_SHIFT{1'b0}}};
    tgt_o      = base_i + scaled_off;
  end
endmodule

// File: rtl/pc_jump_region.sv
module pc_jump_region #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned IDX_W      = 26,
  parameter int unsigned WORD_SHIFT = 2
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [XLEN-1:0]  tgt_o
);
  localparam int unsigned REGION_W = XLEN - IDX_W - WORD_SHIFT;

  logic [XLEN-1:0] pc_low_unused;

  always_comb begin
    pc_low_unused = pc_i;
    tgt_o = {pc_i[XLEN-1 -: REGION_W], idx_i, {WORD_SHIFT{1'b0}}};
  end
endmodule

// File: rtl/pc_target_mux.sv
module pc_target_mux
  import nextpc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [1:0]      sel_i,
  input  logic [XLEN-1:0] seq_i,
  input  logic [XLEN-1:0] br_i,
  input  logic [XLEN-1:0] reg_i,
  input  logic [XLEN-1:0] jmp_i,
  output logic [XLEN-1:0] next_o
);
  always_comb begin
    next_o = seq_i;
    case (pcsel_e'(sel_i))
      PCSEL_SEQ:    next_o = seq_i;
      PCSEL_BRANCH: next_o = br_i;
      PCSEL_REG:    next_o = reg_i;
      PCSEL_JUMP:   next_o = jmp_i;
      default:      next_o = seq_i;
    endcase
  end
endmodule

// File: rtl/nextpc_gen.sv
module nextpc_gen
  import nextpc_pkg::*;
(
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] instr_i,
  input  logic [XLEN-1:0] rs_val_i,
  input  logic [1:0]      pc_sel_i,
  output logic [XLEN-1:0] next_pc_o,
  output logic [XLEN-1:0] link_o
);
  localparam int unsigned REGION_W = XLEN - JMP_IDX_W - WORD_SHIFT;

  logic [XLEN-1:0] seq_addr;
  logic [XLEN-1:0] br_addr;
  logic [XLEN-1:0] jmp_addr;
  logic            unused_opcode;

  assign unused_opcode = &instr_i[XLEN-1:JMP_IDX_W];

  pc_seq_adder #(.XLEN(XLEN), .STEP_BYTES(STEP_BYTES)) u_seq (
    .pc_i  (pc_i),
    .seq_o (seq_addr)
  );

  pc_branch_target #(.XLEN(XLEN), .OFF_W(BR_OFF_W), .WORD_SHIFT(WORD_SHIFT)) u_br (
    .base_i (seq_addr),
    .off_i  (instr_i[BR_OFF_W-1:0]),
    .tgt_o  (br_addr)
  );

  pc_jump_region #(.XLEN(XLEN), .IDX_W(JMP_IDX_W), .WORD_SHIFT(WORD_SHIFT)) u_jmp (
    .pc_i  (pc_i),
    .idx_i (instr_i[JMP_IDX_W-1:0]),
    .tgt_o (jmp_addr)
  );

  pc_target_mux #(.XLEN(XLEN)) u_mux (
    .sel_i  (pc_sel_i),
    .seq_i  (seq_addr),
    .br_i   (br_addr),
    .reg_i  (rs_val_i),
    .jmp_i  (jmp_addr),
    .next_o (next_pc_o)
  );

  assign link_o = seq_addr;

  always_comb begin
    if (!$isunknown(pc_sel_i) && !$isunknown(pc_i)) begin
      if (pc_sel_i == PCSEL_SEQ)
        assert_seq_matches_link_R1: assert (next_pc_o == link_o);
      if (pc_sel_i == PCSEL_REG)
        assert_reg_passthrough_R5: assert (next_pc_o == rs_val_i);
      if (pc_sel_i == PCSEL_JUMP)
        assert_jump_keeps_region_R7: assert (next_pc_o[XLEN-1 -: REGION_W] == pc_i[XLEN-1 -: REGION_W]);
      if (pc_sel_i == PCSEL_JUMP)
        assert_jump_word_aligned_R6: assert (next_pc_o[WORD_SHIFT-1:0] == '0);
      if (pc_sel_i == PCSEL_BRANCH)
        assert_branch_keeps_alignment_R3: assert (next_pc_o[WORD_SHIFT-1:0] == pc_i[WORD_SHIFT-1:0]);
    end
  end
endmodule

// File: tb/nextpc_gen_bench.sv
module nextpc_gen_bench;
  logic        clk;
  logic [31:0] pc, instr, rs;
  logic [1:0]  sel;
  logic [31:0] next_pc, link;

  typedef struct {
    logic [31:0] exp_next;
    logic [31:0] exp_link;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;

  nextpc_gen u_nextpc_gen (
    .pc_i      (pc),
    .instr_i   (instr),
    .rs_val_i  (rs),
    .pc_sel_i  (sel),
    .next_pc_o (next_pc),
    .link_o    (link)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] model(input logic [31:0] p, input logic [31:0] ins,
                                        input logic [31:0] r, input logic [1:0] s);
    logic [31:0] seq;
    seq = p + 32'd4;
    case (s)
      2'b00:   return seq;
      2'b01:   return seq + {{14{ins[15]}}, ins[15:0], 2'b00};
      2'b10:   return r;
      default: return {p[31:28], ins[25:0], 2'b00};
    endcase
  endfunction

  task automatic drive(input logic [31:0] p, input logic [31:0] ins,
                       input logic [31:0] r, input logic [1:0] s,
                       input logic [31:0] exp_next, input string tag);
    item_t it;
    @(posedge clk);
    #0.5;
    pc = p; instr = ins; rs = r; sel = s;
    it.exp_next = exp_next;
    it.exp_link = p + 32'd4;
    it.tag      = tag;
    sb_q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (next_pc !== it.exp_next) begin
        fails++;
        $display("FAIL %s next_pc actual=%h expected=%h", it.tag, next_pc, it.exp_next);
      end
      checks++;
      if (link !== it.exp_link) begin
        fails++;
        $display("FAIL R2 (%s) link actual=%h expected=%h", it.tag, link, it.exp_link);
      end
    end
  end

  initial begin
    pc = '0; instr = '0; rs = '0; sel = 2'b00;
    // idle state: all inputs zero
    drive(32'h0, 32'h0, 32'h0, 2'b00, 32'h4, "R1 idle");
    // R1 sequential
    drive(32'h0040_0100, 32'h0, 32'h0, 2'b00, 32'h0040_0104, "R1");
    // R9 sequential ignores instr and rs
    drive(32'h0040_0100, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 2'b00, 32'h0040_0104, "R9 seq");
    // R3 forward branch
    drive(32'h0040_0100, 32'h1000_0010, 32'h0, 2'b01, 32'h0040_0144, "R3");
    drive(32'h0040_0100, 32'h1000_7FFF, 32'h0, 2'b01, 32'h0042_0100, "R3 max");
    // R4 backward branch
    drive(32'h0040_0100, 32'h1000_FFFF, 32'h0, 2'b01, 32'h0040_0100, "R4");
    drive(32'h0040_0100, 32'h1000_8000, 32'h0, 2'b01, 32'h003E_0104, "R4 min");
    // R9 branch ignores rs
    drive(32'h0040_0100, 32'h1000_0010, 32'h1234_5678, 2'b01, 32'h0040_0144, "R9 br");
    // R5 register indirect, low bits kept
    drive(32'h0040_0100, 32'h0, 32'h8000_0003, 2'b10, 32'h8000_0003, "R5");
    drive(32'h0040_0100, 32'hFFFF_FFFF, 32'h0000_0001, 2'b10, 32'h0000_0001, "R5 odd");
    // R6 absolute jump
    drive(32'h3000_0000, 32'h0800_0040, 32'h0, 2'b11, 32'h3000_0100, "R6");
    drive(32'hA123_4568, 32'hFFFF_FFFF, 32'h5555_5555, 2'b11, 32'hAFFF_FFFC, "R6 R9 jmp");
    // R7 region boundary: pc+4 = 0x10000000, but target keeps 0x0
    drive(32'h0FFF_FFFC, 32'h0800_0010, 32'h0, 2'b11, 32'h0000_0040, "R7");
    // R8 wrap
    drive(32'hFFFF_FFFC, 32'h0, 32'h0, 2'b00, 32'h0000_0000, "R8 seq");
    drive(32'hFFFF_FFF8, 32'h1000_0004, 32'h0, 2'b01, 32'h0000_000C, "R8 br");
    drive(32'h0000_0000, 32'h1000_FFFE, 32'h0, 2'b01, 32'hFFFF_FFFC, "R8 br back");
    // sweep against the model
    for (int k = 0; k < 24; k++) begin
      logic [31:0] p, ins, r;
      logic [1:0]  s;
      p   = 32'h1357_9BDC * (k + 1);
      ins = 32'h2468_ACE1 ^ (k * 32'h0101_0101);
      r   = ~p;
      s   = 2'(k);
      drive(p, ins, r, s, model(p, ins, r, s), "R3 R5 R6 sweep");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule